// File: doc/BRIEF.md
# Event Timer with Capture and Compare

A 32-bit free-running counter block with four compare channels and two capture channels, controlled through a small register bus. The count advances either on a programmable divider of the system clock (time base mode) or on chosen edges of one external event input (event counting mode). Compare channels watch the count. On a hit they can raise a flag, force the count back to zero, halt counting, and drive a dedicated output pin. Capture channels record the count when their input shows a selected edge. All eight flags live in one status word that software clears by writing ones to it.

The bus is single-cycle. The address, write strobe and write data are sampled on the rising clock edge, and read data is a combinational decode of the address. Event inputs are asynchronous. Each one passes through a two-flop synchroniser and a third edge-history flop, so an input change becomes a capture or count event on the third rising edge after it.

Register offsets in bytes:

| Offset | Register |
|---|---|
| 0x00 | status |
| 0x04 | run control |
| 0x08 | count |
| 0x0C | divider limit |
| 0x10 | divider count |
| 0x14 | compare control |
| 0x18, 0x1C, 0x20, 0x24 | compare values 0 to 3 |
| 0x28 | capture control |
| 0x2C, 0x30 | capture values 0 and 1 |
| 0x3C | pin control |
| 0x70 | count-source control |

Top module: `evtimer`

## Requirements
- R1: After reset every register reads 0, `match_out` is 0 and `irq` is 0.
- R2: In time base mode (count-source bits [1:0] = 00) with run bit 0 set, the count rises by one every (divider limit + 1) clocks. The divider count at 0x10 steps 0..limit and then wraps.
- R3: While run-control bit 1 is set, the count and the divider are held at 0. With both run bits clear, the count holds its value.
- R4: In event counting mode, count-source bits [1:0] choose the edge: 01 counts rising edges, 10 counts falling edges, 11 counts both. Bits [3:2] choose which event input is counted. The divider is bypassed.
- R5: Capture control holds 3 bits per channel i at bits [3i+2:3i]. Bit 3i captures on a rising edge, bit 3i+1 captures on a falling edge, and bit 3i+2 enables that channel's flag. A selected edge loads the current count into the capture register (read-only) three clocks after the input change.
- R6: Status bits 0..3 are the compare flags of channels 0..3. Bits 4..7 are the capture flags of channels 0..3. Writing a 1 to a status bit clears that flag, and writing a 0 leaves it unchanged. `irq` is the OR of the flags.
- R7: Compare control holds 3 bits per channel i at bits [3i+2:3i]: bit 3i enables the flag, bit 3i+1 zeroes the count, and bit 3i+2 stops the count. A hit is a count step taken while the count equals the channel's compare value. A flag is set only on a hit with its flag enable set.
- R8: On a hit with the zero bit set, the count becomes 0 instead of incrementing, so the count cycles 0..compare value.
- R9: On a hit with the stop bit set, run bit 0 clears and the count keeps the compare value.
- R10: Pin control bits [3:0] are the `match_out` levels and are writable. Bits [2i+5:2i+4] give channel i's pin action on each hit, regardless of its flag enable: 00 none, 01 drive 0, 10 drive 1, 11 invert.
- R11: If a flag is set by an event in the same clock that software writes a 1 to clear it, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| cap_in | input | N_CAP | Asynchronous event inputs |
| match_out | output | N_MATCH | Compare-driven output pins |
| irq | output | 1 | OR of all status flags |

## Verification
The bench issues a clear-by-write in the exact clock in which a capture sets the same flag. A design that lets the clear win loses that event, and the flag reads 0. It runs a zero-on-hit channel and watches that the count never passes the compare value and wraps to 0 one step after it. An off-by-one compare shows up as a maximum of 4 or 6. It stops the count on a hit and checks that the count holds the compare value and run bit 0 reads 0; a design that steps once more reads 4. It pulses an unselected event input and counts falling and double edges, so a design that ignores the select bits or confuses edge codes returns a wrong event total.

// File: rtl/evtimer_pkg.sv
package evtimer_pkg;

   localparam int unsigned BUS_W = 32;

   localparam logic [7:0] OFS_STATUS = 8'h00;
   localparam logic [7:0] OFS_RUN    = 8'h04;
   localparam logic [7:0] OFS_COUNT  = 8'h08;
   localparam logic [7:0] OFS_DIVLIM = 8'h0C;
   localparam logic [7:0] OFS_DIVCNT = 8'h10;
   localparam logic [7:0] OFS_CMPCTL = 8'h14;
   localparam logic [7:0] OFS_CMPV0  = 8'h18;
   localparam logic [7:0] OFS_CAPCTL = 8'h28;
   localparam logic [7:0] OFS_CAPV0  = 8'h2C;
   localparam logic [7:0] OFS_PINCTL = 8'h3C;
   localparam logic [7:0] OFS_SRC    = 8'h70;

   typedef enum logic [1:0] {
      SRC_TIMEBASE = 2'b00,
      SRC_RISE     = 2'b01,
      SRC_FALL     = 2'b10,
      SRC_BOTH     = 2'b11
   } src_mode_e;

   typedef enum logic [1:0] {
      PIN_KEEP = 2'b00,
      PIN_LOW  = 2'b01,
      PIN_HIGH = 2'b10,
      PIN_INV  = 2'b11
   } pin_act_e;

endpackage

// File: rtl/evtimer_sync_edge.sv
module evtimer_sync_edge #(
   parameter int unsigned N      = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] din,
   output logic [N-1:0] rise,
   output logic [N-1:0] fall
);

   if (STAGES < 2) begin : g_bad_stages
      $error("evtimer_sync_edge: STAGES must be at least 2");
   end

   for (genvar i = 0; i < N; i++) begin : g_ch
      logic [STAGES:0] shf;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) shf <= '0;
         else        shf <= {shf[STAGES-1:0], din[i]};
      end

      assign rise[i] =  shf[STAGES-1] & ~shf[STAGES];
      assign fall[i] = ~shf[STAGES-1] &  shf[STAGES];
   end

endmodule

// File: rtl/evtimer_tick.sv
module evtimer_tick
   import evtimer_pkg::*;
#(
   parameter int unsigned CNT_W = 32,
   parameter int unsigned N_CAP = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             hold,
   input  logic [1:0]       mode,
   input  logic [1:0]       sel,
   input  logic [CNT_W-1:0] div_lim,
   input  logic [N_CAP-1:0] rise,
   input  logic [N_CAP-1:0] fall,
   output logic             tick,
   output logic [CNT_W-1:0] div_cnt
);

   localparam int unsigned SEL_N = 4;

   logic [SEL_N-1:0] rise_pad, fall_pad;
   logic             div_wrap, ev_hit, tb_mode;
   src_mode_e        mode_e;

   for (genvar j = 0; j < SEL_N; j++) begin : g_pad
      if (j < N_CAP) begin : g_live
         assign rise_pad[j] = rise[j];
         assign fall_pad[j] = fall[j];
      end else begin : g_dead
         assign rise_pad[j] = 1'b0;
         assign fall_pad[j] = 1'b0;
      end
   end

   assign mode_e   = src_mode_e'(mode);
   assign tb_mode  = (mode_e == SRC_TIMEBASE);
   assign div_wrap = (div_cnt >= div_lim);

   always_comb begin
      unique case (mode_e)
         SRC_RISE: ev_hit = rise_pad[sel];
         SRC_FALL: ev_hit = fall_pad[sel];
         SRC_BOTH: ev_hit = rise_pad[sel] | fall_pad[sel];
         default:  ev_hit = 1'b0;
      endcase
   end

   assign tick = run & (tb_mode ? div_wrap : ev_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 div_cnt <= '0;
      else if (hold)              div_cnt <= '0;
      else if (run && tb_mode)    div_cnt <= div_wrap ? '0 : div_cnt + 1'b1;
   end

   AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> (div_cnt == '0)); // R3

endmodule

// File: rtl/evtimer_match.sv
module evtimer_match
   import evtimer_pkg::*;
#(
   parameter int unsigned CNT_W   = 32,
   parameter int unsigned N_MATCH = 4
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            tick,
   input  logic [CNT_W-1:0]                count,
   input  logic [N_MATCH-1:0][CNT_W-1:0]   cmp_val,
   input  logic [2*N_MATCH-1:0]            pin_act,
   input  logic                            pin_we,
   input  logic [N_MATCH-1:0]              pin_wd,
   output logic [N_MATCH-1:0]              hit,
   output logic [N_MATCH-1:0]              pin
);

   for (genvar i = 0; i < N_MATCH; i++) begin : g_ch
      pin_act_e act;

      assign act    = pin_act_e'(pin_act[2*i +: 2]);
      assign hit[i] = tick & (count == cmp_val[i]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pin[i] <= 1'b0;
         end else if (hit[i] && act != PIN_KEEP) begin
            unique case (act)
               PIN_LOW:  pin[i] <= 1'b0;
               PIN_HIGH: pin[i] <= 1'b1;
               default:  pin[i] <= ~pin[i];
            endcase
         end else if (pin_we) begin
            pin[i] <= pin_wd[i];
         end
      end

      AST_PIN_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
         (hit[i] && act == PIN_INV) |=> (pin[i] != $past(pin[i]))); // R10
      AST_PIN_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
         (hit[i] && act == PIN_HIGH) |=> pin[i]); // R10
   end

endmodule

// File: rtl/evtimer.sv
module evtimer
   import evtimer_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned CNT_W       = 32,
   parameter int unsigned N_MATCH     = 4,
   parameter int unsigned N_CAP       = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   input  logic [N_CAP-1:0]   cap_in,
   output logic [N_MATCH-1:0] match_out,
   output logic               irq
);

   localparam int unsigned FLAG_W  = 8;
   localparam int unsigned CH_MAX  = 4;
   localparam int unsigned MCTL_W  = 3 * N_MATCH;
   localparam int unsigned CCTL_W  = 3 * N_CAP;
   localparam int unsigned ACT_W   = 2 * N_MATCH;
   localparam int unsigned ACT_LSB = 4;

   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
   localparam logic [ADDR_W-1:0] A_RUN    = ADDR_W'(OFS_RUN);
   localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFS_COUNT);
   localparam logic [ADDR_W-1:0] A_DIVLIM = ADDR_W'(OFS_DIVLIM);
   localparam logic [ADDR_W-1:0] A_DIVCNT = ADDR_W'(OFS_DIVCNT);
   localparam logic [ADDR_W-1:0] A_CMPCTL = ADDR_W'(OFS_CMPCTL);
   localparam logic [ADDR_W-1:0] A_CMPV0  = ADDR_W'(OFS_CMPV0);
   localparam logic [ADDR_W-1:0] A_CAPCTL = ADDR_W'(OFS_CAPCTL);
   localparam logic [ADDR_W-1:0] A_CAPV0  = ADDR_W'(OFS_CAPV0);
   localparam logic [ADDR_W-1:0] A_PINCTL = ADDR_W'(OFS_PINCTL);
   localparam logic [ADDR_W-1:0] A_SRC    = ADDR_W'(OFS_SRC);

   if (ADDR_W < 7 || ADDR_W > 16) begin : g_bad_addr
      $error("evtimer: ADDR_W must be 7..16");
   end
   if (CNT_W < 2 || CNT_W > BUS_W) begin : g_bad_cnt
      $error("evtimer: CNT_W must be 2..32");
   end
   if (N_MATCH < 1 || N_MATCH > CH_MAX) begin : g_bad_match
      $error("evtimer: N_MATCH must be 1..4");
   end
   if (N_CAP < 1 || N_CAP > CH_MAX) begin : g_bad_cap
      $error("evtimer: N_CAP must be 1..4");
   end

   // ---------------- register state ----------------
   logic [FLAG_W-1:0]              status;
   logic [1:0]                     run_ctl;
   logic [CNT_W-1:0]               count;
   logic [CNT_W-1:0]               div_lim;
   logic [MCTL_W-1:0]              cmp_ctl;
   logic [N_MATCH-1:0][CNT_W-1:0]  cmp_val;
   logic [CCTL_W-1:0]              cap_ctl;
   logic [N_CAP-1:0][CNT_W-1:0]    cap_val;
   logic [ACT_W-1:0]               pin_act;
   logic [3:0]                     src_ctl;

   logic [CNT_W-1:0]   div_cnt;
   logic               tick, run, hold;
   logic [N_CAP-1:0]   ev_rise, ev_fall, cap_evt, cap_fen;
   logic [N_MATCH-1:0] hit, m_fen, m_zero, m_stop;
   logic [FLAG_W-1:0]  set_vec;
   logic               any_zero, any_stop;

   logic we_status, we_run, we_divlim, we_cmpctl, we_capctl, we_pin, we_src;

   assign we_status = bus_wr && (bus_addr == A_STATUS);
   assign we_run    = bus_wr && (bus_addr == A_RUN);
   assign we_divlim = bus_wr && (bus_addr == A_DIVLIM);
   assign we_cmpctl = bus_wr && (bus_addr == A_CMPCTL);
   assign we_capctl = bus_wr && (bus_addr == A_CAPCTL);
   assign we_pin    = bus_wr && (bus_addr == A_PINCTL);
   assign we_src    = bus_wr && (bus_addr == A_SRC);

   assign hold = run_ctl[1];
   assign run  = run_ctl[0] & ~run_ctl[1];

   // ---------------- sub-blocks ----------------
   evtimer_sync_edge #(.N(N_CAP), .STAGES(SYNC_STAGES)) u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (cap_in),
      .rise (ev_rise),
      .fall (ev_fall)
   );

   evtimer_tick #(.CNT_W(CNT_W), .N_CAP(N_CAP)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .hold   (hold),
      .mode   (src_ctl[1:0]),
      .sel    (src_ctl[3:2]),
      .div_lim(div_lim),
      .rise   (ev_rise),
      .fall   (ev_fall),
      .tick   (tick),
      .div_cnt(div_cnt)
   );

   evtimer_match #(.CNT_W(CNT_W), .N_MATCH(N_MATCH)) u_match (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .count  (count),
      .cmp_val(cmp_val),
      .pin_act(pin_act),
      .pin_we (we_pin),
      .pin_wd (bus_wdata[N_MATCH-1:0]),
      .hit    (hit),
      .pin    (match_out)
   );

   // ---------------- per-channel decode ----------------
   for (genvar i = 0; i < N_MATCH; i++) begin : g_mctl
      assign m_fen[i]  = cmp_ctl[3*i];
      assign m_zero[i] = cmp_ctl[3*i+1];
      assign m_stop[i] = cmp_ctl[3*i+2];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cmp_val[i] <= '0;
         else if (bus_wr && bus_addr == A_CMPV0 + ADDR_W'(4*i))
            cmp_val[i] <= bus_wdata[CNT_W-1:0];
      end
   end

   for (genvar i = 0; i < N_CAP; i++) begin : g_cap
      assign cap_evt[i] = (cap_ctl[3*i]   & ev_rise[i]) |
                          (cap_ctl[3*i+1] & ev_fall[i]);
      assign cap_fen[i] = cap_ctl[3*i+2];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          cap_val[i] <= '0;
         else if (cap_evt[i]) cap_val[i] <= count;
      end

      AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
         cap_evt[i] |=> (cap_val[i] == $past(count))); // R5
   end

   for (genvar j = 0; j < CH_MAX; j++) begin : g_flags
      if (j < N_MATCH) begin : g_m
         assign set_vec[j] = hit[j] & m_fen[j];
      end else begin : g_m0
         assign set_vec[j] = 1'b0;
      end
      if (j < N_CAP) begin : g_c
         assign set_vec[CH_MAX+j] = cap_evt[j] & cap_fen[j];
      end else begin : g_c0
         assign set_vec[CH_MAX+j] = 1'b0;
      end
   end

   assign any_zero = |(hit & m_zero);
   assign any_stop = |(hit & m_stop);

   // ---------------- control registers ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_lim <= '0;
         cmp_ctl <= '0;
         cap_ctl <= '0;
         pin_act <= '0;
         src_ctl <= '0;
      end else begin
         if (we_divlim) div_lim <= bus_wdata[CNT_W-1:0];
         if (we_cmpctl) cmp_ctl <= bus_wdata[MCTL_W-1:0];
         if (we_capctl) cap_ctl <= bus_wdata[CCTL_W-1:0];
         if (we_pin)    pin_act <= bus_wdata[ACT_LSB +: ACT_W];
         if (we_src)    src_ctl <= bus_wdata[3:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_ctl <= '0;
      end else begin
         if (we_run)   run_ctl    <= bus_wdata[1:0];
         if (any_stop) run_ctl[0] <= 1'b0;
      end
   end

   // ---------------- count ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        count <= '0;
      else if (hold)     count <= '0;
      else if (tick) begin
         if (any_zero)      count <= '0;
         else if (!any_stop) count <= count + 1'b1;
      end
   end

   // ---------------- status flags ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status <= '0;
      else        status <= (status & ~(we_status ? bus_wdata[FLAG_W-1:0] : '0)) | set_vec;
   end

   assign irq = |status;

   // ---------------- read decode ----------------
   always_comb begin
      bus_rdata = '0;
      if (bus_addr == A_STATUS)      bus_rdata[FLAG_W-1:0] = status;
      else if (bus_addr == A_RUN)    bus_rdata[1:0]        = run_ctl;
      else if (bus_addr == A_COUNT)  bus_rdata[CNT_W-1:0]  = count;
      else if (bus_addr == A_DIVLIM) bus_rdata[CNT_W-1:0]  = div_lim;
      else if (bus_addr == A_DIVCNT) bus_rdata[CNT_W-1:0]  = div_cnt;
      else if (bus_addr == A_CMPCTL) bus_rdata[MCTL_W-1:0] = cmp_ctl;
      else if (bus_addr == A_CAPCTL) bus_rdata[CCTL_W-1:0] = cap_ctl;
      else if (bus_addr == A_SRC)    bus_rdata[3:0]        = src_ctl;
      else if (bus_addr == A_PINCTL) begin
         bus_rdata[N_MATCH-1:0]       = match_out;
         bus_rdata[ACT_LSB +: ACT_W]  = pin_act;
      end else begin
         for (int i = 0; i < N_MATCH; i++)
            if (bus_addr == A_CMPV0 + ADDR_W'(4*i)) bus_rdata[CNT_W-1:0] = cmp_val[i];
         for (int i = 0; i < N_CAP; i++)
            if (bus_addr == A_CAPV0 + ADDR_W'(4*i)) bus_rdata[CNT_W-1:0] = cap_val[i];
      end
   end

   // ---------------- assertions ----------------
   AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> (count == '0)); // R3
   AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (run_ctl == 2'b00) |=> (count == $past(count))); // R3
   AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      we_status |=> ((status & $past(bus_wdata[FLAG_W-1:0] & ~set_vec)) == '0)); // R6
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_vec) |=> ((status & $past(set_vec)) == $past(set_vec))); // R11
   AST_ZERO_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      any_zero |=> (count == '0)); // R8
   AST_STOP_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (any_stop && !any_zero) |=> (!run_ctl[0] && count == $past(count))); // R9

endmodule

// File: tb/evtimer_bench.sv
`timescale 1ns/1ps
module evtimer_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [1:0]  cap_in = '0;
   logic [3:0]  match_out;
   logic        irq;

   int unsigned n_checks = 0;
   int unsigned n_fails  = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   evtimer u_evtimer (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (bus_addr),
      .bus_wr   (bus_wr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .cap_in   (cap_in),
      .match_out(match_out),
      .irq      (irq)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   // drive at a negedge; commits at the next posedge; returns at the following negedge
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(input int idx);
      cap_in[idx] = 1'b1;
      idle(4);
      cap_in[idx] = 1'b0;
      idle(4);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      logic [7:0]  adrs [15] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18,
                                 8'h1C, 8'h20, 8'h24, 8'h28, 8'h2C, 8'h30, 8'h3C, 8'h70};
      foreach (adrs[k]) begin
         rd(adrs[k], d);
         chk("R1", $sformatf("reset value at 0x%0h", adrs[k]), d, 0);
      end
      chk("R1", "match_out after reset", {28'd0, match_out}, 0);
      chk("R1", "irq after reset", {31'd0, irq}, 0);
   endtask

   task automatic t_divider();
      logic [31:0] d, frozen;
      wr(8'h0C, 32'd2);
      wr(8'h04, 32'd2);
      wr(8'h04, 32'd1);
      idle(9);
      rd(8'h08, d);  chk("R2", "count after 9 clocks, limit 2", d, 3);
      rd(8'h10, d);  chk("R2", "divider count at wrap", d, 0);
      idle(1);
      rd(8'h10, d);  chk("R2", "divider count one later", d, 1);
      wr(8'h04, 32'd0);
      rd(8'h08, frozen);
      idle(10);
      rd(8'h08, d);  chk("R3", "count frozen with run bits clear", d, frozen);
      wr(8'h04, 32'd3);
      idle(5);
      rd(8'h08, d);  chk("R3", "count under hold", d, 0);
      rd(8'h10, d);  chk("R3", "divider under hold", d, 0);
   endtask

   task automatic t_events();
      logic [31:0] d;
      wr(8'h70, 32'h5);              // rising edges of input 1
      wr(8'h04, 32'd2);
      wr(8'h04, 32'd1);
      pulse(1); pulse(1); pulse(1);
      pulse(0);                      // unselected input
      rd(8'h08, d);  chk("R4", "rising edges of input 1 only", d, 3);
      wr(8'h70, 32'h7);              // both edges
      wr(8'h04, 32'd2);
      wr(8'h04, 32'd1);
      pulse(1); pulse(1); pulse(1);
      rd(8'h08, d);  chk("R4", "both edges counted", d, 6);
      wr(8'h70, 32'h6);              // falling edges
      wr(8'h04, 32'd2);
      wr(8'h04, 32'd1);
      pulse(1); pulse(1);
      rd(8'h08, d);  chk("R4", "falling edges counted", d, 2);
      wr(8'h04, 32'd0);
      wr(8'h70, 32'h0);
   endtask

   task automatic t_capture();
      logic [31:0] d;
      wr(8'h0C, 32'd0);
      wr(8'h04, 32'd2);
      wr(8'h04, 32'd1);
      idle(7);
      wr(8'h04, 32'd0);
      rd(8'h08, d);  chk("R2", "count with limit 0 steps every clock", d, 8);
      wr(8'h28, 32'h15);             // ch0 rise + flag, ch1 fall no flag
      cap_in[0] = 1'b1;
      idle(4);
      rd(8'h2C, d);  chk("R5", "capture 0 on rising edge", d, 8);
      rd(8'h00, d);  chk("R6", "capture 0 flag in bit 4", d, 32'h10);
      chk("R6", "irq with a flag set", {31'd0, irq}, 1);
      cap_in[1] = 1'b1;
      idle(4);
      rd(8'h30, d);  chk("R5", "capture 1 ignores rising edge", d, 0);
      cap_in[1] = 1'b0;
      idle(4);
      rd(8'h30, d);  chk("R5", "capture 1 on falling edge", d, 8);
      rd(8'h00, d);  chk("R5", "capture 1 flag disabled", d, 32'h10);
      wr(8'h00, 32'h00);
      rd(8'h00, d);  chk("R6", "writing zero keeps flags", d, 32'h10);
      wr(8'h00, 32'h10);
      rd(8'h00, d);  chk("R6", "writing one clears flag", d, 0);
      chk("R6", "irq after clear", {31'd0, irq}, 0);
      cap_in[0] = 1'b0;
      idle(4);
   endtask

   task automatic t_set_wins();
      logic [31:0] d;
      cap_in[0] = 1'b1;              // event lands three posedges later
      idle(2);
      wr(8'h00, 32'h10);             // clear commits on that same edge
      rd(8'h00, d);  chk("R11", "capture set beats clear", d, 32'h10);
      wr(8'h00, 32'h10);
      rd(8'h00, d);  chk("R11", "later clear succeeds", d, 0);
      cap_in[0] = 1'b0;
      idle(4);
      wr(8'h28, 32'h0);
   endtask

   task automatic t_zero_on_hit();
      logic [31:0] d;
      int unsigned top = 0;
      wr(8'h04, 32'd2);
      wr(8'h18, 32'd5);
      wr(8'h14, 32'h3);              // ch0 flag + zero
      wr(8'h3C, 32'h30);             // ch0 invert, pins 0
      wr(8'h00, 32'hFF);
      wr(8'h04, 32'd1);
      idle(7);
      rd(8'h08, d);  chk("R8", "count wrapped after hit at 5", d, 1);
      rd(8'h00, d);  chk("R7", "compare 0 flag in bit 0", d, 32'h01);
      chk("R10", "invert action on pin 0", {28'd0, match_out}, 32'h1);
      for (int k = 0; k < 24; k++) begin
         @(negedge clk);
         rd(8'h08, d);
         if (d > top) top = d;
      end
      chk("R8", "largest count with zero-on-hit", top, 5);
      wr(8'h04, 32'd0);
   endtask

   task automatic t_stop_on_hit();
      logic [31:0] d;
      wr(8'h04, 32'd2);
      wr(8'h1C, 32'd3);
      wr(8'h20, 32'd2);
      wr(8'h14, 32'h68);             // ch1 flag+stop, ch2 flag, ch3 none
      wr(8'h3C, 32'h184);            // ch1 drive 1, ch2 drive 0, pin2 preset
      wr(8'h00, 32'hFF);
      wr(8'h04, 32'd1);
      idle(10);
      rd(8'h08, d);  chk("R9", "count stops at compare value", d, 3);
      rd(8'h04, d);  chk("R9", "run bit cleared by stop", d, 0);
      rd(8'h00, d);  chk("R7", "flags 1,2 only (ch3 hit, flag off)", d, 32'h06);
      chk("R10", "drive-1 and drive-0 pin actions", {28'd0, match_out}, 32'h2);
      rd(8'h3C, d);  chk("R10", "pin control readback", d, 32'h182);
   endtask

   initial begin
      idle(4);
      rst_n = 1'b1;
      idle(1);
      t_reset();
      t_divider();
      t_events();
      t_capture();
      t_set_wins();
      t_zero_on_hit();
      t_stop_on_hit();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL R1 watchdog actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

endmodule